// File: doc/BRIEF.md
# I2C Interrupt Status and Clear Unit

This block gathers the interrupt sources of an I2C controller into one status word. Ten of the sources are one-cycle event pulses from the controller: general call, START or repeated START, STOP, bus activity, read done, transmit abort, read request, transmit overflow, receive overflow and receive underflow. Each pulse sets a sticky bit. The two remaining sources follow the receive and transmit queue fill levels live, by comparing each level with a programmable threshold.

A mask register selects which status bits drive the single interrupt line. Software clears sticky bits by reading, either through a dedicated clear address for one event or through a combined address that clears every sticky bit. The register port is a plain strobe interface. Read data is combinational in the cycle of the read strobe. Writes and clears take effect at the next clock edge.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_i[k]`, for k in {0,1,3,5,6,7,8,9,10,11}, sets status bit k at the next edge. The bit then holds until it is cleared. The status word at address 0 is read-only, and writes to it change nothing. Bit map: 11 general call, 10 START/restart, 9 STOP, 8 activity, 7 read done, 6 transmit abort, 5 read request, 4 transmit-empty level, 3 transmit overflow, 2 receive-full level, 1 receive overflow, 0 receive underflow.
- R2: A read of a dedicated clear address returns the prior state of its bit in data bit 0 and clears only that bit at the next edge. The address-to-bit pairs are 6→0, 7→1, 8→3, 9→5, 10→6, 11→7, 12→8, 13→9, 14→10, 15→11.
- R3: A read of address 5 returns the full status word and clears all sticky bits at the next edge.
- R4: Status bit 2 is 1 exactly while `rx_level_i` is at least the receive threshold (address 3) plus one.
- R5: Status bit 4 is 1 exactly while `tx_level_i` is at or below the transmit threshold (address 4).
- R6: Bits 4 and 2 ignore event pulses and clear reads.
- R7: When an event pulse arrives in the same cycle as a read that clears its bit, the bit stays set.
- R8: The masked status (address 1) is the status word ANDed with the mask (address 2, bits 11:0). `irq_o` is 1 exactly when the masked status is nonzero.
- R9: After reset all sticky bits, the mask and both thresholds are 0. The interrupt line is therefore 0.
- R10: The mask and the thresholds read back what was written. Every unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 12 | Event pulses, one per status bit (bits 4 and 2 unused) |
| rx_level_i | input | LEVEL_W | Receive queue fill level |
| tx_level_i | input | LEVEL_W | Transmit queue fill level |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and the interrupt line are combinational. The bench therefore samples them one time step after it drives inputs on the falling edge, in the same cycle as the stimulus. Event pulses, clears and register writes show up only after the following rising edge. The bench reference model updates its sticky bits and registers at that edge too, so each check compares against the state the design holds in that cycle. Level bits react in the same cycle as a change in fill level, and the threshold boundary cases are checked that way.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   localparam int NSRC = 12;
   localparam int B_RXFULL  = 2;
   localparam int B_TXEMPTY = 4;
   // sticky sources: every bit except the two level comparisons
   localparam logic [NSRC-1:0] STICKY = 12'hFEB;
   // word addresses
   localparam int RA_RAW    = 0;
   localparam int RA_MASKED = 1;
   localparam int RA_MASK   = 2;
   localparam int RA_RXTHR  = 3;
   localparam int RA_TXTHR  = 4;
   localparam int RA_CLRALL = 5;
   localparam int RA_CLR0   = 6;
   localparam int NCLR      = 10;
   localparam int CLR_IDX [NCLR] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
endpackage

// File: rtl/i2c_irq_event_bank.sv
module i2c_irq_event_bank
   import i2c_irq_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] evt_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] sticky_o
);
   for (genvar k = 0; k < NSRC; k++) begin : g_bit
      if (STICKY[k]) begin : g_latch
         logic q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) q <= 1'b0;
            else         q <= evt_i[k] | (q & ~clr_i[k]);
         end
         assign sticky_o[k] = q;
      end else begin : g_none
         assign sticky_o[k] = 1'b0;
      end
   end
endmodule

// File: rtl/i2c_irq_level_cmp.sv
module i2c_irq_level_cmp #(
   parameter int LEVEL_W = 5
) (
   input  logic [LEVEL_W-1:0] rx_level_i,
   input  logic [LEVEL_W-1:0] tx_level_i,
   input  logic [LEVEL_W-1:0] rx_thr_i,
   input  logic [LEVEL_W-1:0] tx_thr_i,
   output logic               rx_full_o,
   output logic               tx_empty_o
);
   localparam int CW = LEVEL_W + 1;
   logic [CW-1:0] rx_need;
   assign rx_need    = CW'(rx_thr_i) + CW'(1);
   assign rx_full_o  = CW'(rx_level_i) >= rx_need;
   assign tx_empty_o = tx_level_i <= tx_thr_i;
endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
   import i2c_irq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter int LEVEL_W = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rd_i,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NSRC-1:0]    status_i,
   output logic [NSRC-1:0]    mask_o,
   output logic [LEVEL_W-1:0] rx_thr_o,
   output logic [LEVEL_W-1:0] tx_thr_o,
   output logic [NSRC-1:0]    clr_o,
   output logic [DATA_W-1:0]  rdata_o
);
   int unsigned a;
   assign a = int'(addr_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mask_o   <= '0;
         rx_thr_o <= '0;
         tx_thr_o <= '0;
      end else if (wr_i) begin
         if (a == RA_MASK)  mask_o   <= wdata_i[NSRC-1:0];
         if (a == RA_RXTHR) rx_thr_o <= wdata_i[LEVEL_W-1:0];
         if (a == RA_TXTHR) tx_thr_o <= wdata_i[LEVEL_W-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      clr_o   = '0;
      if (a == RA_RAW)    rdata_o[NSRC-1:0]    = status_i;
      if (a == RA_MASKED) rdata_o[NSRC-1:0]    = status_i & mask_o;
      if (a == RA_MASK)   rdata_o[NSRC-1:0]    = mask_o;
      if (a == RA_RXTHR)  rdata_o[LEVEL_W-1:0] = rx_thr_o;
      if (a == RA_TXTHR)  rdata_o[LEVEL_W-1:0] = tx_thr_o;
      if (a == RA_CLRALL) begin
         rdata_o[NSRC-1:0] = status_i;
         if (rd_i) clr_o = STICKY;
      end
      for (int j = 0; j < NCLR; j++) begin
         if (a == RA_CLR0 + j) begin
            rdata_o[0] = status_i[CLR_IDX[j]];
            if (rd_i) clr_o[CLR_IDX[j]] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
   import i2c_irq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter int LEVEL_W = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NSRC-1:0]    evt_i,
   input  logic [LEVEL_W-1:0] rx_level_i,
   input  logic [LEVEL_W-1:0] tx_level_i,
   input  logic               reg_rd_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               irq_o
);
   if (DATA_W < NSRC) begin : g_bad_data
      $error("DATA_W must hold the status word");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (LEVEL_W < 1 || LEVEL_W > DATA_W) begin : g_bad_lvl
      $error("LEVEL_W out of range");
   end

   logic [NSRC-1:0]    sticky_w, clr_w, mask_w, status_w;
   logic [LEVEL_W-1:0] rx_thr_w, tx_thr_w;
   logic               rx_full_w, tx_empty_w;

   i2c_irq_event_bank u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
      .clr_i(clr_w), .sticky_o(sticky_w)
   );

   i2c_irq_level_cmp #(.LEVEL_W(LEVEL_W)) u_cmp (
      .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
      .rx_thr_i(rx_thr_w), .tx_thr_i(tx_thr_w),
      .rx_full_o(rx_full_w), .tx_empty_o(tx_empty_w)
   );

   always_comb begin
      status_w            = sticky_w;
      status_w[B_RXFULL]  = rx_full_w;
      status_w[B_TXEMPTY] = tx_empty_w;
   end

   i2c_irq_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
      .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .status_i(status_w),
      .mask_o(mask_w), .rx_thr_o(rx_thr_w), .tx_thr_o(tx_thr_w),
      .clr_o(clr_w), .rdata_o(reg_rdata_o)
   );

   assign irq_o = |(status_w & mask_w);
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
   import i2c_irq_pkg::*;
#(
   parameter int LEVEL_W = 5
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NSRC-1:0]    evt_i,
   input logic [NSRC-1:0]    clr_w,
   input logic [NSRC-1:0]    sticky_w,
   input logic [NSRC-1:0]    status_w,
   input logic [NSRC-1:0]    mask_w,
   input logic [LEVEL_W-1:0] rx_level_i,
   input logic [LEVEL_W-1:0] tx_level_i,
   input logic [LEVEL_W-1:0] rx_thr_w,
   input logic [LEVEL_W-1:0] tx_thr_w,
   input logic               irq_o
);
   AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((evt_i & STICKY) != '0) |=> ((sticky_w & $past(evt_i & STICKY)) == $past(evt_i & STICKY))); // R1
   AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_w != '0) |=> ((sticky_w & $past(sticky_w & ~clr_w)) == $past(sticky_w & ~clr_w))); // R1
   AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_w & ~evt_i) != '0) |=> ((sticky_w & $past(clr_w & ~evt_i)) == '0)); // R2
   AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_w & evt_i & STICKY) != '0) |=> ((sticky_w & $past(clr_w & evt_i & STICKY)) == $past(clr_w & evt_i & STICKY))); // R7
   AST_RX_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_level_i > rx_thr_w) |-> status_w[B_RXFULL]); // R4
   AST_TX_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_level_i <= tx_thr_w) |-> status_w[B_TXEMPTY]); // R5
   AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_w == '0) |-> !irq_o); // R8
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.LEVEL_W(LEVEL_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_w(clr_w),
   .sticky_w(sticky_w), .status_w(status_w), .mask_w(mask_w),
   .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
   .rx_thr_w(rx_thr_w), .tx_thr_w(tx_thr_w), .irq_o(irq_o)
);

// File: tb/sim_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_irq_ctrl;
   localparam int DW = 32;
   localparam int AW = 5;
   localparam int LW = 5;
   localparam logic [11:0] STK = 12'hFEB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   evt = '0;
   logic [LW-1:0] rxl = '0, txl = '0;
   logic          rd = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0, rdata;
   logic          irq;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // reference state
   logic [11:0]   m_stk = '0, m_mask = '0;
   logic [LW-1:0] m_rxthr = '0, m_txthr = '0;

   always #5 clk = ~clk;

   i2c_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .LEVEL_W(LW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .rx_level_i(rxl), .tx_level_i(txl),
      .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   function automatic int clr_bit(int a);
      int t [10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
      if (a >= 6 && a <= 15) return t[a-6];
      return -1;
   endfunction

   function automatic logic [11:0] exp_status(int rl, int tl);
      logic [11:0] s = m_stk;
      s[2] = (rl >= int'(m_rxthr) + 1);
      s[4] = (tl <= int'(m_txthr));
      return s;
   endfunction

   function automatic logic [DW-1:0] exp_read(int a, int rl, int tl);
      logic [11:0] s = exp_status(rl, tl);
      logic [DW-1:0] r = '0;
      case (a)
         0, 5: r[11:0] = s;
         1: r[11:0] = s & m_mask;
         2: r[11:0] = m_mask;
         3: r[LW-1:0] = m_rxthr;
         4: r[LW-1:0] = m_txthr;
         default: if (clr_bit(a) >= 0) r[0] = s[clr_bit(a)];
      endcase
      return r;
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive at falling edge, check combinational outputs, update model at rising edge
   task automatic step(logic [11:0] e, bit r, bit w, int a, logic [DW-1:0] wd,
                       int rl, int tl, string tag);
      logic [11:0] clr;
      @(negedge clk);
      evt = e; rd = r; wr = w; addr = AW'(a); wdata = wd;
      rxl = LW'(rl); txl = LW'(tl);
      #1;
      if (r) check(tag, rdata, exp_read(a, rl, tl));
      check({tag, " irq"}, DW'(irq), DW'(|(exp_status(rl, tl) & m_mask)));
      clr = '0;
      if (r && a == 5) clr = STK;
      if (r && clr_bit(a) >= 0) clr[clr_bit(a)] = 1'b1;
      @(posedge clk);
      m_stk = (e & STK) | (m_stk & ~clr);
      if (w && a == 2) m_mask = wd[11:0];
      if (w && a == 3) m_rxthr = wd[LW-1:0];
      if (w && a == 4) m_txthr = wd[LW-1:0];
   endtask

   task automatic rd_at(int a, string tag);
      step('0, 1, 0, a, '0, int'(rxl), int'(txl), tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // reset state R9
      step('0, 1, 0, 0, '0, 0, 0, "R9");
      step('0, 1, 0, 2, '0, 0, 0, "R9");
      step('0, 1, 0, 3, '0, 0, 0, "R9");
      // R10 read-back and unmapped
      step('0, 0, 1, 4, 32'd3, 0, 0, "R10");
      step('0, 1, 0, 4, '0, 0, 0, "R10");
      step('0, 1, 0, 20, '0, 0, 0, "R10");
      // R1 set and hold, read-only raw
      step(12'h200, 0, 0, 0, '0, 0, 9, "R1");
      step(12'h800, 0, 1, 0, 32'h0, 0, 9, "R1");
      rd_at(0, "R1");
      // R2 single clear (STOP, bit 9 at address 13)
      rd_at(13, "R2");
      rd_at(13, "R2");
      rd_at(0, "R2");
      // R7 event with its own clear (general call, address 15)
      step(12'h800, 1, 0, 15, '0, 0, 9, "R7");
      rd_at(0, "R7");
      // R4/R5 boundaries
      step('0, 0, 1, 3, 32'd5, 0, 9, "R4");
      step('0, 1, 0, 0, '0, 5, 3, "R4");
      step('0, 1, 0, 0, '0, 6, 3, "R4");
      step('0, 1, 0, 0, '0, 6, 4, "R5");
      // R6 level bits survive clears and ignore pulses
      step(12'h014, 1, 0, 5, '0, 6, 3, "R3");
      rd_at(0, "R6");
      step(12'h014, 0, 0, 0, '0, 0, 9, "R6");
      rd_at(0, "R6");
      // R3 combined clear
      step(12'hFEB, 0, 0, 0, '0, 0, 9, "R3");
      rd_at(5, "R3");
      rd_at(0, "R3");
      // R8 mask gating
      step(12'h040, 0, 1, 2, 32'h040, 0, 9, "R8");
      rd_at(1, "R8");
      step('0, 0, 1, 2, 32'h0, 0, 9, "R8");
      rd_at(1, "R8");
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] e = 12'($urandom) & 12'($urandom);
         bit r = ($urandom_range(0, 2) == 0);
         bit w = !r && ($urandom_range(0, 5) == 0);
         int a = $urandom_range(0, 17);
         logic [DW-1:0] wd = DW'($urandom_range(0, 15));
         if (w && a == 2) wd = DW'($urandom);
         step(e, r, w, a, wd, $urandom_range(0, 16), $urandom_range(0, 16), "R1/R2/R3/R8");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule